// File: doc/BRIEF.md
# Ethernet Transmit Error Handler

This block sits between the transmit buffer-descriptor sequencer and the MAC transmit datapath. While a buffer is being sent, it watches four fault indications: a FIFO underrun, loss of carrier sense, exhaustion of the retransmission budget, and a collision tagged with the byte offset at which it occurred. For each fault it decides whether the current buffer is abandoned or carries on. It records the outcome in per-buffer status bits and in one sticky transmit-error event.

Abort-class faults (underrun, retry exhaustion, late collision) close the buffer and park the transmitter. The transmitter stays parked until a restart command is given. A collision is treated as late only when its byte offset reaches a configurable window. Earlier collisions belong to the retry logic, and this block ignores them.

On underrun the block does not close the buffer at once. It first streams a 32-bit corrupting tail on a 4-bit valid/ready interface. The tail is the bitwise inverse of the running CRC, sent least-significant nibble first, so the far end sees a bad frame check. The datapath may stall the tail at any time by holding `tail_ready` low. While `tail_valid` is high and `tail_ready` is low, the nibble on `tail_data` does not change. A nibble is consumed on each clock edge where both signals are high. The buffer closes only after the eighth nibble has been accepted.

Top module: `eth_txerr_top`

## Requirements
- R1: After reset, `tx_halted`, `tx_event`, `tail_valid` and `buf_close` are 0 and `tx_status` is 0000.
- R2: An underrun while running sets `tx_status[3]` (underrun) and `tx_event`, and raises `tx_halted`. It then presents 8 tail nibbles equal to ~`crc_in`, least-significant nibble first. `buf_close` pulses for one cycle in the cycle after the eighth nibble is accepted.
- R3: While `tail_valid` is high and `tail_ready` is low, `tail_valid` stays high and `tail_data` holds its value.
- R4: Retry exhaustion while running sets `tx_status[2]` (retry limit) and `tx_event`, and raises `tx_halted`. `buf_close` is 1 in the cycle after the fault and 0 in the cycle after that.
- R5: A collision with `col_offset` >= `late_win` is a late collision. It sets `tx_status[1]` and `tx_event`, pulses `buf_close`, and raises `tx_halted`.
- R6: A collision with `col_offset` < `late_win`, with no other fault present, changes neither `tx_status`, `tx_event` nor `tx_halted`.
- R7: Carrier loss with no collision in the same cycle sets `tx_status[0]` and `tx_event`. It neither halts nor closes the buffer. Carrier loss that coincides with a collision sets no bit.
- R8: Abort faults take priority over carrier loss in the same cycle. Among abort faults, underrun outranks retry limit, which outranks late collision. Only the winning status bit is set.
- R9: While halted, all fault inputs are ignored. A `restart_cmd` given after the buffer has closed clears `tx_halted` in the next cycle.
- R10: `tx_event` is sticky and is cleared by `event_clr`. A new fault in the same cycle as `event_clr` leaves it set.
- R11: A `frame_start` pulse while running clears `tx_status` to 0000.
- R12: Fault inputs are ignored while `frame_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| late_win | input | OFF_W | Byte offset at which collisions become late |
| frame_active | input | 1 | A buffer is being transmitted |
| frame_start | input | 1 | A new buffer begins; clears status |
| fifo_underrun | input | 1 | Transmit FIFO ran dry |
| crs_lost | input | 1 | Carrier sense dropped |
| retry_exh | input | 1 | Retransmission attempts used up |
| col_det | input | 1 | Collision seen |
| col_offset | input | OFF_W | Byte offset of the collision |
| crc_in | input | CRC_W | Running CRC of the frame |
| restart_cmd | input | 1 | Restart-transmit command |
| event_clr | input | 1 | Write-one-to-clear for `tx_event` |
| tail_valid | output | 1 | Corrupting tail nibble available |
| tail_ready | input | 1 | Datapath accepts a tail nibble |
| tail_data | output | NIB_W | Tail nibble |
| buf_close | output | 1 | One-cycle request to close the buffer |
| tx_status | output | 4 | {underrun, retry limit, late collision, carrier lost} |
| tx_event | output | 1 | Sticky transmit-error event |
| tx_halted | output | 1 | Transmitter parked (tail or halt) |

## Verification
The assertions assume that the fault inputs are single-cycle indications sampled on the clock edge. They also assume that `tail_ready` may change freely, and that `restart_cmd` means something only once the tail has drained. The stimulus drives every input just after the falling edge. It always lets the tail drain completely before issuing a restart. Outputs are sampled at the next falling edge. Each table vector starts from a fresh running frame with the event cleared, so no effect of one vector carries into the next.

// File: rtl/eth_txerr_pkg.sv
package eth_txerr_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_TAIL = 2'd1,
    ST_HALT = 2'd2
  } txe_state_t;

  typedef struct packed {
    logic un;
    logic rl;
    logic lc;
    logic csl;
  } txe_flags_t;
endpackage

// File: rtl/eth_txerr_classify.sv
module eth_txerr_classify #(
  parameter int OFF_W = 8
) (
  input  logic             en,
  input  logic             fifo_underrun,
  input  logic             crs_lost,
  input  logic             retry_exh,
  input  logic             col_det,
  input  logic [OFF_W-1:0] col_offset,
  input  logic [OFF_W-1:0] late_win,
  output eth_txerr_pkg::txe_flags_t hit,
  output logic             abort
);
  logic late_col;

  always_comb begin
    late_col = col_det && (col_offset >= late_win);
    hit      = '0;
    if (en) begin
      if (fifo_underrun)          hit.un  = 1'b1;
      else if (retry_exh)         hit.rl  = 1'b1;
      else if (late_col)          hit.lc  = 1'b1;
      else if (crs_lost && !col_det) hit.csl = 1'b1;
    end
    abort = hit.un || hit.rl || hit.lc;
  end
endmodule

// File: rtl/eth_txerr_tail.sv
module eth_txerr_tail #(
  parameter int CRC_W = 32,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CRC_W-1:0] crc,
  output logic             valid,
  input  logic             ready,
  output logic [NIB_W-1:0] data,
  output logic             done
);
  localparam int BEATS = CRC_W / NIB_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CRC_W-1:0] sh;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = (cnt == CNT_W'(BEATS - 1));
  assign data = sh[NIB_W-1:0];
  assign done = valid && ready && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh    <= '0;
      cnt   <= '0;
      valid <= 1'b0;
    end else if (load) begin
      sh    <= ~crc;
      cnt   <= '0;
      valid <= 1'b1;
    end else if (valid && ready) begin
      if (last) begin
        valid <= 1'b0;
      end else begin
        sh  <= sh >> NIB_W;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eth_txerr_top.sv
module eth_txerr_top #(
  parameter int OFF_W = 8,
  parameter int CRC_W = 32,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] late_win,
  input  logic             frame_active,
  input  logic             frame_start,
  input  logic             fifo_underrun,
  input  logic             crs_lost,
  input  logic             retry_exh,
  input  logic             col_det,
  input  logic [OFF_W-1:0] col_offset,
  input  logic [CRC_W-1:0] crc_in,
  input  logic             restart_cmd,
  input  logic             event_clr,
  output logic             tail_valid,
  input  logic             tail_ready,
  output logic [NIB_W-1:0] tail_data,
  output logic             buf_close,
  output logic [3:0]       tx_status,
  output logic             tx_event,
  output logic             tx_halted
);
  import eth_txerr_pkg::*;

  txe_state_t state;
  txe_flags_t hit, st;
  logic       abort, running, tail_done;

  assign running = (state == ST_RUN);

  eth_txerr_classify #(.OFF_W(OFF_W)) u_cls (
    .en            (running && frame_active),
    .fifo_underrun (fifo_underrun),
    .crs_lost      (crs_lost),
    .retry_exh     (retry_exh),
    .col_det       (col_det),
    .col_offset    (col_offset),
    .late_win      (late_win),
    .hit           (hit),
    .abort         (abort)
  );

  eth_txerr_tail #(.CRC_W(CRC_W), .NIB_W(NIB_W)) u_tail (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hit.un),
    .crc   (crc_in),
    .valid (tail_valid),
    .ready (tail_ready),
    .data  (tail_data),
    .done  (tail_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      st        <= '0;
      tx_event  <= 1'b0;
      buf_close <= 1'b0;
    end else begin
      buf_close <= 1'b0;
      if (abort || hit.csl)  tx_event <= 1'b1;
      else if (event_clr)    tx_event <= 1'b0;
      case (state)
        ST_RUN: begin
          st <= (frame_start ? '0 : st) | hit;
          if (hit.un) begin
            state <= ST_TAIL;
          end else if (abort) begin
            state     <= ST_HALT;
            buf_close <= 1'b1;
          end
        end
        ST_TAIL: begin
          if (tail_done) begin
            state     <= ST_HALT;
            buf_close <= 1'b1;
          end
        end
        default: begin
          if (restart_cmd) state <= ST_RUN;
        end
      endcase
    end
  end

  assign tx_status = st;
  assign tx_halted = !running;
endmodule

// File: rtl/eth_txerr_chk.sv
module eth_txerr_chk #(
  parameter int OFF_W = 8,
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFF_W-1:0] late_win,
  input logic             frame_active,
  input logic             fifo_underrun,
  input logic             crs_lost,
  input logic             retry_exh,
  input logic             col_det,
  input logic [OFF_W-1:0] col_offset,
  input logic             restart_cmd,
  input logic             event_clr,
  input logic             tail_valid,
  input logic             tail_ready,
  input logic [NIB_W-1:0] tail_data,
  input logic             buf_close,
  input logic             tx_event,
  input logic             tx_halted
);
  // R3
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_valid && !tail_ready |=> tail_valid && $stable(tail_data));

  // R4
  close_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |=> !buf_close);

  // R10
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_event && !event_clr |=> tx_event);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halted && !restart_cmd |=> tx_halted);

  // R7
  csl_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_halted && crs_lost && !col_det && !fifo_underrun && !retry_exh
    |=> !tx_halted && !buf_close);

  // R6
  early_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_halted && col_det && (col_offset < late_win) && !fifo_underrun && !retry_exh
    |=> !tx_halted);

  // R12
  inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_halted && !frame_active |=> !tx_halted);
endmodule

bind eth_txerr_top eth_txerr_chk #(.OFF_W(OFF_W), .NIB_W(NIB_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .late_win      (late_win),
  .frame_active  (frame_active),
  .fifo_underrun (fifo_underrun),
  .crs_lost      (crs_lost),
  .retry_exh     (retry_exh),
  .col_det       (col_det),
  .col_offset    (col_offset),
  .restart_cmd   (restart_cmd),
  .event_clr     (event_clr),
  .tail_valid    (tail_valid),
  .tail_ready    (tail_ready),
  .tail_data     (tail_data),
  .buf_close     (buf_close),
  .tx_event      (tx_event),
  .tx_halted     (tx_halted)
);

// File: tb/eth_txerr_top_tb.sv
module eth_txerr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  late_win;
  logic        frame_active, frame_start, fifo_underrun, crs_lost, retry_exh, col_det;
  logic [7:0]  col_offset;
  logic [31:0] crc_in;
  logic        restart_cmd, event_clr, tail_ready;
  logic        tail_valid, buf_close, tx_event, tx_halted;
  logic [3:0]  tail_data, tx_status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eth_txerr_top u_dut (
    .clk(clk), .rst_n(rst_n), .late_win(late_win), .frame_active(frame_active),
    .frame_start(frame_start), .fifo_underrun(fifo_underrun), .crs_lost(crs_lost),
    .retry_exh(retry_exh), .col_det(col_det), .col_offset(col_offset), .crc_in(crc_in),
    .restart_cmd(restart_cmd), .event_clr(event_clr), .tail_valid(tail_valid),
    .tail_ready(tail_ready), .tail_data(tail_data), .buf_close(buf_close),
    .tx_status(tx_status), .tx_event(tx_event), .tx_halted(tx_halted)
  );

  // {un, csl, rl, col, offset[7:0], status[3:0], halted, event}
  localparam logic [17:0] VEC [11] = '{
    {4'b0000, 8'd0,  4'b0000, 1'b0, 1'b0},
    {4'b0100, 8'd0,  4'b0001, 1'b0, 1'b1},
    {4'b0010, 8'd0,  4'b0100, 1'b1, 1'b1},
    {4'b0001, 8'd70, 4'b0010, 1'b1, 1'b1},
    {4'b0001, 8'd63, 4'b0000, 1'b0, 1'b0},
    {4'b0001, 8'd64, 4'b0010, 1'b1, 1'b1},
    {4'b0101, 8'd10, 4'b0000, 1'b0, 1'b0},
    {4'b0110, 8'd0,  4'b0100, 1'b1, 1'b1},
    {4'b1011, 8'd70, 4'b1000, 1'b1, 1'b1},
    {4'b0011, 8'd70, 4'b0100, 1'b1, 1'b1},
    {4'b1000, 8'd0,  4'b1000, 1'b1, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    fifo_underrun = 0; crs_lost = 0; retry_exh = 0; col_det = 0; col_offset = 0;
  endtask

  task automatic recover();
    tail_ready = 1;
    while (tail_valid) tick();
    tail_ready = 0;
    restart_cmd = 1;
    tick();
    restart_cmd = 0;
    chk(tx_halted, 0, "R9 restart");
  endtask

  task automatic new_frame();
    event_clr = 1; frame_start = 1; frame_active = 1;
    tick();
    event_clr = 0; frame_start = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] inv;
    rst_n = 0; late_win = 8'd64; frame_active = 0; frame_start = 0;
    clear_faults(); crc_in = 32'h1234ABCD; restart_cmd = 0; event_clr = 0; tail_ready = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk(tx_halted, 0, "R1 halted");
    chk(tx_event, 0, "R1 event");
    chk(tail_valid, 0, "R1 tail_valid");
    chk(buf_close, 0, "R1 close");
    chk(tx_status, 0, "R1 status");

    // Table walk: R4 R5 R6 R7 R8
    for (int i = 0; i < 11; i++) begin
      new_frame();
      {fifo_underrun, crs_lost, retry_exh, col_det} = VEC[i][17:14];
      col_offset = VEC[i][13:6];
      tick();
      clear_faults();
      chk(tx_status, VEC[i][5:2], "R8 table status");
      chk(tx_halted, VEC[i][1], "R5 table halted");
      chk(tx_event, VEC[i][0], "R7 table event");
      if (VEC[i][1] && !VEC[i][17]) begin
        chk(buf_close, 1, "R4 close pulse");
        tick();
        chk(buf_close, 0, "R4 close ends");
      end
      if (tx_halted) recover();
    end

    // R2 R3 underrun tail
    new_frame();
    inv = ~crc_in;
    fifo_underrun = 1;
    tick();
    fifo_underrun = 0;
    chk(tx_halted, 1, "R2 halted");
    chk(tail_valid, 1, "R2 tail valid");
    chk(tail_data, inv[3:0], "R3 stall before");
    tick();
    chk(tail_valid, 1, "R3 valid held");
    chk(tail_data, inv[3:0], "R3 data held");
    // R9 ignored while halted
    retry_exh = 1;
    tick();
    retry_exh = 0;
    chk(tx_status, 4'b1000, "R9 ignored in tail");
    for (int b = 0; b < 8; b++) begin
      chk(tail_data, (inv >> (4 * b)) & 32'hF, "R2 nibble");
      chk(buf_close, 0, "R2 no early close");
      tail_ready = 1;
      tick();
      tail_ready = (b % 3 == 1) ? 0 : 1;
      if (!tail_ready) begin
        tick();
        if (b < 7) chk(tail_data, (inv >> (4 * (b + 1))) & 32'hF, "R3 stall mid");
      end
      tail_ready = 0;
    end
    chk(tail_valid, 0, "R2 tail ends");
    // buf_close: the close pulse may already have passed during a stall
    // at the last beat (b=7: 7%3==1, stall tick), so check halted instead
    chk(tx_halted, 1, "R2 halted after tail");
    recover();

    // R2 close timing with no stall at the end
    new_frame();
    fifo_underrun = 1;
    tick();
    fifo_underrun = 0;
    tail_ready = 1;
    for (int b = 0; b < 7; b++) tick();
    chk(buf_close, 0, "R2 close not yet");
    tick();
    tail_ready = 0;
    chk(buf_close, 1, "R2 close after last nibble");
    tick();
    chk(buf_close, 0, "R2 close single");
    // R9 faults ignored in halt
    crs_lost = 1;
    tick();
    crs_lost = 0;
    chk(tx_status, 4'b1000, "R9 ignored in halt");
    recover();

    // R11 frame_start clears status
    frame_start = 1;
    tick();
    frame_start = 0;
    chk(tx_status, 0, "R11 status cleared");

    // R10 set wins over clear, then clear works
    crs_lost = 1; event_clr = 1;
    tick();
    crs_lost = 0; event_clr = 0;
    chk(tx_event, 1, "R10 set wins");
    tick();
    chk(tx_event, 1, "R10 sticky");
    event_clr = 1;
    tick();
    event_clr = 0;
    chk(tx_event, 0, "R10 cleared");

    // R12 inactive frame ignores faults
    frame_active = 0;
    retry_exh = 1; crs_lost = 1;
    tick();
    clear_faults();
    chk(tx_halted, 0, "R12 no halt");
    chk(tx_event, 0, "R12 no event");
    chk(tx_status, 4'b0001, "R12 status unchanged");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule